// File: doc/BRIEF.md
# Bit-Serial Adder with Carry State

This block adds two binary numbers one bit position per clock. On each cycle the caller presents one bit of each operand, least significant position first. The block returns one sum bit for that position and keeps the carry between cycles in a single flip-flop. Word framing, length counting and serialisation are the caller's job. Before each new addition, the caller pulses a synchronous active-low clear for one cycle. The clear zeroes the carry, and the operand pair offered in that cycle is thrown away.

A parameter picks one of two output forms. In the combinational (Mealy) form, the sum bit for a position shows on `z` in the same cycle the operand bits are offered. In the registered (Moore) form, a four-state machine holds both the carry and the sum, so `z` shows the sum of a position one cycle after its operands. In both forms, `carry_out` is the stored carry. After the last bit position has been clocked in, it is the carry-out of the whole word.

Top module: `bitser_adder`

## Requirements
- R1: While `rst_n` is low, `carry_out` reads 0 and, in the registered form, `z` reads 0. The reset takes effect without waiting for a clock edge.
- R2: A clock edge with `clr_n` low leaves `carry_out` at 0 and, in the registered form, `z` at 0. This holds whatever `a` and `b` are, including `a`=`b`=1.
- R3: In the combinational form, `z` equals `a` XOR `b` XOR `carry_out` within the same cycle.
- R4: A clock edge with `clr_n` high and `a`=`b`=1 makes `carry_out` 1.
- R5: A clock edge with `clr_n` high and `a`=`b`=0 makes `carry_out` 0.
- R6: A clock edge with `clr_n` high and `a` different from `b` leaves `carry_out` unchanged.
- R7: In the registered form, after a clock edge with `clr_n` high, `z` equals `a` XOR `b` XOR `carry_out` as they were before that edge.
- R8: Operands fed bit 0 first after a clear give the bits of their arithmetic sum. In the combinational form, sum bit i appears in cycle i. In the registered form, it appears in cycle i+1. After the last bit edge, `carry_out` equals the word's carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| clr_n | input | 1 | Synchronous active-low clear; starts a new addition |
| a | input | 1 | Current bit of operand A |
| b | input | 1 | Current bit of operand B |
| z | output | 1 | Sum bit (same cycle or one cycle late, per form) |
| carry_out | output | 1 | Stored carry; word carry-out after the last bit |

## Verification
The synchronous clear and the carry-generate case (`a`=`b`=1) can fall in the same clock cycle. If the wrong one wins, the next addition starts with a stale carry. To provoke this, the bench drives `a`=`b`=1 in every clear cycle of an exhaustive sweep over all pairs of 4-bit operands, run on both output forms together. The result is judged in the first bit cycle that follows: `carry_out` must read 0, the registered `z` must read 0, and the combinational `z` must equal the plain XOR of the first operand bits.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  typedef enum logic {
    FORM_MEALY = 1'b0,
    FORM_MOORE = 1'b1
  } form_e;

  function automatic logic sum_bit(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic carry_next(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

endpackage

// File: rtl/bitser_carry_reg.sv
module bitser_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic a,
  input  logic b,
  output logic carry_q
);
  import bitser_pkg::*;

  logic carry_d;

  always_comb begin
    if (!clr_n) carry_d = 1'b0;
    else        carry_d = carry_next(a, b, carry_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && a && b) |=> carry_q);                            // R4
  AST_CARRY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !a && !b) |=> !carry_q);                         // R5
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && (a != b)) |=> (carry_q == $past(carry_q)));      // R6
  AST_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !carry_q);                                      // R2

endmodule

// File: rtl/bitser_sum_comb.sv
module bitser_sum_comb (
  input  logic a,
  input  logic b,
  input  logic carry_q,
  output logic sum_o
);
  import bitser_pkg::*;

  always_comb sum_o = sum_bit(a, b, carry_q);

endmodule

// File: rtl/bitser_sum_reg.sv
module bitser_sum_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic a,
  input  logic b,
  input  logic carry_q,
  output logic sum_q
);
  import bitser_pkg::*;

  logic sum_d;

  always_comb begin
    if (!clr_n) sum_d = 1'b0;
    else        sum_d = sum_bit(a, b, carry_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= sum_d;
  end

  AST_SUM_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n |=> (sum_q == ($past(a) ^ $past(b) ^ $past(carry_q))));  // R7
  AST_CLEAR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !sum_q);                                             // R2

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter bitser_pkg::form_e FORM = bitser_pkg::FORM_MEALY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic a,
  input  logic b,
  output logic z,
  output logic carry_out
);
  import bitser_pkg::*;

  logic carry_q;

  bitser_carry_reg u_carry (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .a       (a),
    .b       (b),
    .carry_q (carry_q)
  );

  generate
    if (FORM == FORM_MOORE) begin : g_moore
      bitser_sum_reg u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .a       (a),
        .b       (b),
        .carry_q (carry_q),
        .sum_q   (z)
      );
    end else begin : g_mealy
      bitser_sum_comb u_sum (
        .a       (a),
        .b       (b),
        .carry_q (carry_q),
        .sum_o   (z)
      );
    end
  endgenerate

  assign carry_out = carry_q;

endmodule

// File: tb/bitser_adder_tb.sv
module bitser_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, clr_n, a, b;
  logic z_mealy, co_mealy, z_moore, co_moore;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitser_adder #(.FORM(bitser_pkg::FORM_MEALY)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .a(a), .b(b),
    .z(z_mealy), .carry_out(co_mealy));

  bitser_adder #(.FORM(bitser_pkg::FORM_MOORE)) u_dut_moore (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .a(a), .b(b),
    .z(z_moore), .carry_out(co_moore));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; a = 1'b0; b = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mealy carry in reset", co_mealy, 1'b0);
    chk("R1 moore carry in reset", co_moore, 1'b0);
    chk("R1 moore z in reset", z_moore, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    clr_n = 1'b0; a = 1'b1; b = 1'b1;
    @(posedge clk); #1;

    for (int opa = 0; opa < (1 << W); opa++) begin
      for (int opb = 0; opb < (1 << W); opb++) begin
        int total;
        total = opa + opb;
        for (int i = 0; i <= W; i++) begin
          int   msk;
          logic cexp;
          string clab;
          if (i < W) begin
            clr_n = 1'b1; a = opa[i]; b = opb[i];
          end else begin
            clr_n = 1'b0; a = 1'b1; b = 1'b1;   // clear collides with generate
          end
          @(negedge clk);
          msk  = (1 << i) - 1;
          cexp = 1'(((opa & msk) + (opb & msk)) >> i);
          if (i == 0)                        clab = "R2 carry after clear";
          else if (i == W)                   clab = "R8 word carry-out";
          else if (opa[i-1] && opb[i-1])     clab = "R4 carry generate";
          else if (!opa[i-1] && !opb[i-1])   clab = "R5 carry kill";
          else                               clab = "R6 carry propagate";
          chk({clab, " mealy"}, co_mealy, cexp);
          chk({clab, " moore"}, co_moore, cexp);
          if (i < W) chk("R3 R8 mealy z same cycle", z_mealy, 1'(total >> i));
          if (i == 0) chk("R2 moore z after clear", z_moore, 1'b0);
          else        chk("R7 R8 moore z one cycle late", z_moore, 1'(total >> (i-1)));
          @(posedge clk); #1;
        end
      end
    end

    clr_n = 1'b1; a = 1'b1; b = 1'b1;
    @(posedge clk); #1;
    chk("R4 carry set before async reset", co_mealy, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async reset mealy carry", co_mealy, 1'b0);
    chk("R1 async reset moore carry", co_moore, 1'b0);
    chk("R1 async reset moore z", z_moore, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule